// File: doc/BRIEF.md
# Almost-Flag Offset Configuration Loader

This block holds the two threshold offsets a FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. On a synchronous master reset it samples a two-bit select and a method input. Three select codes load one fixed offset into both registers at once. The fourth code leaves the registers waiting for values supplied by the user, either as two words on the data bus or as a bit stream on a serial input.

While user offsets are still outstanding, the ready output is low. The write-enable input is then consumed by the loader and no FIFO write is accepted. Once both offsets hold valid values, ready rises and writes pass through again, except during a partial reset. A partial reset never touches the offsets, the ready state or the latched method. Only a master reset can select a new method.

Top module: `ofs_cfg_loader`

## Requirements
- R1: After the asynchronous reset rst_ni, both offsets equal 8 (saturated to DEPTH-1), ready_o is 1, and the latched method is the fixed-offset method.
- R2: A master reset (mrst_i high at a clock edge) with sel_i = 2'b00, 2'b01 or 2'b10 sets both offsets to 8, 16 or 64 respectively, each saturated to DEPTH-1, and sets ready_o to 1 after that edge.
- R3: A master reset with sel_i = 2'b11 clears ready_o after that edge. It latches mode_i as the loading method: 0 selects parallel loading and 1 selects serial loading.
- R4: In parallel loading, the first edge with wr_en_i high and ready_o low loads the almost-empty offset from data_i. The second such edge loads the almost-full offset, and ready_o is 1 after that second edge.
- R5: A parallel value on data_i greater than DEPTH-1 is stored as DEPTH-1.
- R6: In serial loading, each edge with wr_en_i high and ready_o low takes one bit from sd_i. The first AW bits form the almost-empty offset and the next AW bits form the almost-full offset, each least significant bit first. ready_o is 1 after the 2*AW-th bit.
- R7: An edge with wr_en_i low leaves the offsets, ready_o and any loading progress unchanged.
- R8: wr_ok_o equals wr_en_i AND ready_o AND NOT prst_i.
- R9: prst_i changes neither the offsets, nor ready_o, nor the latched method, nor any loading progress.
- R10: When mrst_i is low, sel_i and mode_i have no effect. While ready_o is 1, data_i, sd_i and wr_en_i do not change the offsets.
- R11: A master reset discards any partly loaded offset or partly shifted bits. Loading restarts from the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrst_i | input | 1 | Synchronous master reset; samples sel_i and mode_i |
| prst_i | input | 1 | Partial reset; blocks FIFO writes only |
| sel_i | input | 2 | Offset select: 00=8, 01=16, 10=64, 11=user loading |
| mode_i | input | 1 | User loading method: 0 parallel, 1 serial |
| wr_en_i | input | 1 | Write enable; doubles as load strobe while not ready |
| data_i | input | DW | Parallel offset value |
| sd_i | input | 1 | Serial offset bit |
| ae_ofs_o | output | AW | Almost-empty offset |
| af_ofs_o | output | AW | Almost-full offset |
| ready_o | output | 1 | Both offsets valid |
| wr_ok_o | output | 1 | FIFO write accepted this cycle |

## Verification
The offsets and ready_o are registered, so their new values are due one edge after the master reset, the load strobe or the final serial bit that causes them. wr_ok_o is combinational and is valid in the same cycle as its inputs. The bench drives inputs just after a rising edge and samples the registered outputs one time unit after the next rising edge. It checks wr_ok_o one time unit after it changes the inputs, still within the same cycle. It sweeps 256 parallel pairs, including values that saturate, and all 256 serial pairs of a 16-deep configuration. Strobe gaps, partial resets and aborts by master reset are placed inside the loading sequences.

// File: rtl/ofs_cfg_pkg.sv
package ofs_cfg_pkg;
  typedef enum logic [1:0] {
    SEL_OFS8  = 2'b00,
    SEL_OFS16 = 2'b01,
    SEL_OFS64 = 2'b10,
    SEL_PROG  = 2'b11
  } ofs_sel_e;

  // fixed offset for a select code, clipped to maxv
  function automatic int unsigned dflt_ofs(logic [1:0] sel, int unsigned maxv);
    int unsigned v;
    case (sel)
      SEL_OFS8:  v = 8;
      SEL_OFS16: v = 16;
      default:   v = 64;
    endcase
    return (v > maxv) ? maxv : v;
  endfunction
endpackage

// File: rtl/ofs_cfg_mode.sv
module ofs_cfg_mode
  import ofs_cfg_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic [1:0]    sel_i,
  input  logic          mode_i,
  output logic          prog_sel_o,
  output logic          ser_o,
  output logic [AW-1:0] dflt_o
);
  localparam int unsigned MAXV = DEPTH - 1;

  logic ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ser_q <= 1'b0;
    else if (mrst_i) ser_q <= mode_i;
  end

  assign prog_sel_o = (sel_i == SEL_PROG);
  assign ser_o      = ser_q;

  always_comb begin
    dflt_o = '0;
    case (sel_i)
      SEL_OFS8:  dflt_o = AW'(dflt_ofs(SEL_OFS8, MAXV));
      SEL_OFS16: dflt_o = AW'(dflt_ofs(SEL_OFS16, MAXV));
      SEL_OFS64: dflt_o = AW'(dflt_ofs(SEL_OFS64, MAXV));
      default:   dflt_o = '0;
    endcase
  end
endmodule

// File: rtl/ofs_par_rx.sv
module ofs_par_rx #(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [AW-1:0] word_o
);
  localparam logic [DW-1:0] MAX_DW = DW'(DEPTH - 1);
  localparam logic [AW-1:0] MAX_AW = AW'(DEPTH - 1);

  assign vld_o  = en_i;
  assign word_o = (data_i > MAX_DW) ? MAX_AW : data_i[AW-1:0];
endmodule

// File: rtl/ofs_ser_rx.sv
module ofs_ser_rx #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          sd_i,
  output logic          vld_o,
  output logic [AW-1:0] word_o
);
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  logic [AW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == LAST);
  assign word_o = {sd_i, sr_q[AW-1:1]};  // lsb-first: new bit enters at the top
  assign vld_o  = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sr_q  <= word_o;
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_cfg_loader.sv
module ofs_cfg_loader
  import ofs_cfg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic [1:0]    sel_i,
  input  logic          mode_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] data_i,
  input  logic          sd_i,
  output logic [AW-1:0] ae_ofs_o,
  output logic [AW-1:0] af_ofs_o,
  output logic          ready_o,
  output logic          wr_ok_o
);
  localparam logic [AW-1:0] RST_OFS = AW'(dflt_ofs(SEL_OFS8, DEPTH - 1));

  logic          prog_sel, ser_mode;
  logic [AW-1:0] dflt;
  logic          load_en;
  logic          par_vld, ser_vld, word_vld;
  logic [AW-1:0] par_word, ser_word, word;
  logic          ready_q, af_next_q;
  logic [AW-1:0] ae_q, af_q;

  ofs_cfg_mode #(.DEPTH(DEPTH)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mrst_i     (mrst_i),
    .sel_i      (sel_i),
    .mode_i     (mode_i),
    .prog_sel_o (prog_sel),
    .ser_o      (ser_mode),
    .dflt_o     (dflt)
  );

  assign load_en = wr_en_i & ~ready_q & ~mrst_i;

  ofs_par_rx #(.DEPTH(DEPTH), .DW(DW)) u_par (
    .en_i   (load_en & ~ser_mode),
    .data_i (data_i),
    .vld_o  (par_vld),
    .word_o (par_word)
  );

  ofs_ser_rx #(.DEPTH(DEPTH)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mrst_i),
    .en_i   (load_en & ser_mode),
    .sd_i   (sd_i),
    .vld_o  (ser_vld),
    .word_o (ser_word)
  );

  assign word_vld = ser_mode ? ser_vld : par_vld;
  assign word     = ser_mode ? ser_word : par_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q      <= RST_OFS;
      af_q      <= RST_OFS;
      ready_q   <= 1'b1;
      af_next_q <= 1'b0;
    end else if (mrst_i) begin
      af_next_q <= 1'b0;
      ready_q   <= ~prog_sel;
      if (!prog_sel) begin
        ae_q <= dflt;
        af_q <= dflt;
      end
    end else if (word_vld) begin
      if (!af_next_q) begin
        ae_q      <= word;
        af_next_q <= 1'b1;
      end else begin
        af_q      <= word;
        af_next_q <= 1'b0;
        ready_q   <= 1'b1;
      end
    end
  end

  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;
  assign ready_o  = ready_q;
  assign wr_ok_o  = wr_en_i & ready_q & ~prst_i;
endmodule

// File: rtl/ofs_cfg_loader_chk.sv
module ofs_cfg_loader_chk
  import ofs_cfg_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mrst_i,
  input logic          prst_i,
  input logic [1:0]    sel_i,
  input logic          wr_en_i,
  input logic [AW-1:0] ae_ofs_o,
  input logic [AW-1:0] af_ofs_o,
  input logic          ready_o,
  input logic          wr_ok_o
);
  function automatic logic [AW-1:0] exp_dflt(logic [1:0] s);
    return AW'(dflt_ofs(s, DEPTH - 1));
  endfunction

  // R2
  a_r2_default_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && sel_i != SEL_PROG) |=> (ready_o && ae_ofs_o == exp_dflt($past(sel_i))
                                       && af_ofs_o == exp_dflt($past(sel_i))));

  // R3
  a_r3_prog_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && sel_i == SEL_PROG) |=> !ready_o);

  // R7
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mrst_i && !wr_en_i) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o) && $stable(ready_o)));

  // R8
  a_r8_no_write_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !wr_ok_o);

  // R8
  a_r8_prst_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |-> !wr_ok_o);

  // R10
  a_r10_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !mrst_i) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o) && ready_o));
endmodule

bind ofs_cfg_loader ofs_cfg_loader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mrst_i   (mrst_i),
  .prst_i   (prst_i),
  .sel_i    (sel_i),
  .wr_en_i  (wr_en_i),
  .ae_ofs_o (ae_ofs_o),
  .af_ofs_o (af_ofs_o),
  .ready_o  (ready_o),
  .wr_ok_o  (wr_ok_o)
);

// File: tb/ofs_cfg_loader_tb_top.sv
module ofs_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int MAXV  = DEPTH - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mrst_i = 1'b0, prst_i = 1'b0, mode_i = 1'b0;
  logic [1:0]    sel_i = 2'b00;
  logic          wr_en_i = 1'b0, sd_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [AW-1:0] ae_ofs_o, af_ofs_o;
  logic          ready_o, wr_ok_o;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ofs_cfg_loader #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk_i, .rst_ni, .mrst_i, .prst_i, .sel_i, .mode_i, .wr_en_i,
    .data_i, .sd_i, .ae_ofs_o, .af_ofs_o, .ready_o, .wr_ok_o
  );

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic mreset(logic [1:0] s, logic m);
    mrst_i = 1'b1; sel_i = s; mode_i = m; wr_en_i = 1'b0;
    cyc();
    mrst_i = 1'b0; sel_i = ~s; mode_i = ~m;  // later changes must not matter (R10)
  endtask

  task automatic par_load(int a, int b, bit gap);
    wr_en_i = 1'b1; data_i = DW'(a);
    cyc();
    wr_en_i = 1'b0;
    chk("R4 ready after first word", int'(ready_o), 0);
    chk("R5 ae value", int'(ae_ofs_o), sat(a));
    if (gap) begin
      data_i = '1;
      cyc(); cyc();
      chk("R7 ready held", int'(ready_o), 0);
      chk("R7 ae held", int'(ae_ofs_o), sat(a));
    end
    wr_en_i = 1'b1; data_i = DW'(b);
    cyc();
    wr_en_i = 1'b0;
    chk("R4 ready after second word", int'(ready_o), 1);
    chk("R5 af value", int'(af_ofs_o), sat(b));
    chk("R4 ae kept", int'(ae_ofs_o), sat(a));
  endtask

  task automatic ser_word(int v, bit gap);
    for (int i = 0; i < AW; i++) begin
      sd_i = v[i]; wr_en_i = 1'b1;
      cyc();
      if (gap) begin
        wr_en_i = 1'b0; sd_i = ~sd_i;
        cyc();
      end
    end
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(3 * CLK_PERIOD + 2);
    // R1 power-on state
    chk("R1 ae reset", int'(ae_ofs_o), 8);
    chk("R1 af reset", int'(af_ofs_o), 8);
    chk("R1 ready reset", int'(ready_o), 1);
    rst_ni = 1'b1;
    cyc();

    // R1 fixed method after reset: a strobe while ready changes nothing
    wr_en_i = 1'b1; data_i = 8'd3; sd_i = 1'b1;
    cyc();
    wr_en_i = 1'b0;
    chk("R1 ae unchanged", int'(ae_ofs_o), 8);

    // R2 fixed offsets, saturated to 15
    for (int s = 0; s < 3; s++) begin
      mreset(2'(s), 1'b0);
      chk("R2 ae default", int'(ae_ofs_o), sat((s == 0) ? 8 : (s == 1) ? 16 : 64));
      chk("R2 af default", int'(af_ofs_o), sat((s == 0) ? 8 : (s == 1) ? 16 : 64));
      chk("R2 ready", int'(ready_o), 1);
    end

    // R8 write acceptance
    wr_en_i = 1'b1; #1;
    chk("R8 wr_ok ready", int'(wr_ok_o), 1);
    prst_i = 1'b1; #1;
    chk("R8 wr_ok prst", int'(wr_ok_o), 0);
    cyc();
    chk("R9 ae after prst", int'(ae_ofs_o), 15);
    prst_i = 1'b0; wr_en_i = 1'b0;

    // R4 R5 parallel sweep, values up to 255 saturate
    for (int a = 0; a < 256; a++) begin
      mreset(2'b11, 1'b0);
      chk("R3 ready low", int'(ready_o), 0);
      wr_en_i = 1'b1; #1;
      chk("R8 wr_ok while loading", int'(wr_ok_o), 0);
      wr_en_i = 1'b0;
      par_load(a, 255 - a, (a % 3) == 0);
    end

    // R10 inputs ignored once ready
    wr_en_i = 1'b1; data_i = 8'd2; sd_i = 1'b1; sel_i = 2'b00; mode_i = 1'b1;
    cyc(); cyc(); cyc();
    wr_en_i = 1'b0;
    chk("R10 ae held", int'(ae_ofs_o), sat(255));
    chk("R10 af held", int'(af_ofs_o), sat(0));

    // R6 serial sweep over all pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        mreset(2'b11, 1'b1);
        chk("R3 ready low serial", int'(ready_o), 0);
        ser_word(a, ((a + b) % 2) == 1);
        chk("R6 ready mid", int'(ready_o), 0);
        chk("R6 ae value", int'(ae_ofs_o), a);
        ser_word(b, ((a + b) % 4) == 0);
        chk("R6 ready done", int'(ready_o), 1);
        chk("R6 af value", int'(af_ofs_o), b);
        chk("R6 ae kept", int'(ae_ofs_o), a);
      end
    end

    // R9 partial reset inside serial loading
    mreset(2'b11, 1'b1);
    sd_i = 1'b1; wr_en_i = 1'b1; cyc(); sd_i = 1'b0; cyc();
    wr_en_i = 1'b0; prst_i = 1'b1;
    cyc(); cyc(); cyc();
    chk("R9 ready during prst", int'(ready_o), 0);
    prst_i = 1'b0;
    sd_i = 1'b1; wr_en_i = 1'b1; cyc(); sd_i = 1'b0; cyc();
    wr_en_i = 1'b0;
    chk("R9 ae progress kept", int'(ae_ofs_o), 5);
    ser_word(9, 1'b0);
    chk("R9 af", int'(af_ofs_o), 9);
    prst_i = 1'b1; cyc(); cyc(); prst_i = 1'b0;
    chk("R9 ready after prst", int'(ready_o), 1);
    chk("R9 ae after prst", int'(ae_ofs_o), 5);

    // R9 method survives partial reset: serial method still active
    mreset(2'b11, 1'b1);
    prst_i = 1'b1; cyc(); prst_i = 1'b0;
    ser_word(6, 1'b0); ser_word(12, 1'b0);
    chk("R9 serial kept ae", int'(ae_ofs_o), 6);
    chk("R9 serial kept af", int'(af_ofs_o), 12);

    // R11 abort of partial serial bits
    mreset(2'b11, 1'b1);
    sd_i = 1'b1; wr_en_i = 1'b1; cyc(); cyc(); cyc();
    wr_en_i = 1'b0;
    mreset(2'b11, 1'b1);
    ser_word(5, 1'b0);
    chk("R11 ae fresh", int'(ae_ofs_o), 5);
    ser_word(10, 1'b0);
    chk("R11 af fresh", int'(af_ofs_o), 10);

    // R11 abort after first parallel word
    mreset(2'b11, 1'b0);
    wr_en_i = 1'b1; data_i = 8'd7; cyc(); wr_en_i = 1'b0;
    mreset(2'b11, 1'b0);
    wr_en_i = 1'b1; data_i = 8'd3; cyc(); data_i = 8'd4; cyc(); wr_en_i = 1'b0;
    chk("R11 par ae", int'(ae_ofs_o), 3);
    chk("R11 par af", int'(af_ofs_o), 4);
    chk("R11 par ready", int'(ready_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule